// File: doc/BRIEF.md
# Padded Instruction Stream Compactor

This block turns a channel program stored in padded form into the dense byte stream a transfer sequencer fetches. In the padded form every instruction starts on a 32-bit slot. Most instructions fill one slot. The address-load instruction fills two slots. Only some bytes of each slot carry meaning. The block reads the opcode in byte 0 of the first slot of each instruction and works out from it how many slots to take in. It then forwards only the bytes that the sequencer decodes, in their original order, and drops the rest.

Words enter on a valid/ready stream and bytes leave on a valid/ready byte stream. The block accepts no new word while it still owes output bytes. It stops after it forwards the terminating opcode and raises `done`. An opcode outside the known set stops it with `error` raised, and no byte of that slot is forwarded. A synchronous `clear` pulse restarts it for the next program.

Top module: `padded_stream_compactor`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `done` and `error` are 0.
- R2: Input words are little-endian: byte k of a word is bits 8k+7:8k. An instruction with opcode 0xBC takes two words and forwards six bytes: bytes 0 and 1 of the first word, then bytes 0, 1, 2, 3 of the second.
- R3: An instruction whose opcode is 0x20, 0x22, 0x34, 0x38 or 0x3C takes one word and forwards its bytes 0 and 1, in that order.
- R4: An instruction whose opcode is 0x04, 0x08 or 0x13 takes one word and forwards only its byte 0.
- R5: Opcode 0x00 forwards one byte of value 0x00. Once that byte is taken, `done` goes to 1 and `in_ready` goes to 0.
- R6: Any other opcode forwards no byte and raises `error`. `in_ready` goes to 0.
- R7: While `done` or `error` is 1, no input word is accepted and no byte is offered, whatever `in_valid` does.
- R8: A `clear` pulse returns the block to its reset state on the next cycle. This holds in any state, including partway through an instruction.
- R9: `in_ready` and `out_valid` are never 1 together. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous restart |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted this cycle |
| in_data | input | 32 | Padded program word |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Output byte taken this cycle |
| out_data | output | 8 | Compacted program byte |
| done | output | 1 | Terminating opcode has been forwarded |
| error | output | 1 | Unknown opcode seen |

## Verification
The bench sends every one of the 256 opcode values as the first byte of a slot. It fills the padding bytes with values that differ from each other and from the opcode. A design that took the wrong number of bytes, or took bytes from the wrong lanes, would therefore produce visibly wrong output. For 0xBC, a design that skipped the second word would forward two bytes instead of six, and one that took bytes 2 and 3 of the first word would forward padding. A near-miss opcode such as 0x21 or 0x3D is expected to stop the block with nothing forwarded; a design that decoded it loosely would emit bytes. A mixed program under stalling `out_ready` checks that bytes hold while stalled and that nothing is lost. It then checks that input offered after `done` is refused. It also checks that `clear` sent partway through an instruction discards the pending second word.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Opcodes that the sequencer decodes; values are fixed by the sequencer.
    localparam logic [7:0] OP_LOAD_ADDR = 8'hBC;
    localparam logic [7:0] OP_LOOP0     = 8'h20;
    localparam logic [7:0] OP_LOOP1     = 8'h22;
    localparam logic [7:0] OP_SIGNAL    = 8'h34;
    localparam logic [7:0] OP_LOOPEND0  = 8'h38;
    localparam logic [7:0] OP_LOOPEND1  = 8'h3C;
    localparam logic [7:0] OP_LOAD      = 8'h04;
    localparam logic [7:0] OP_STORE     = 8'h08;
    localparam logic [7:0] OP_BARRIER   = 8'h13;
    localparam logic [7:0] OP_FINISH    = 8'h00;

    typedef enum logic [2:0] {
        CLS_LONG,
        CLS_PAIR,
        CLS_SINGLE,
        CLS_FINISH,
        CLS_BAD
    } op_class_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EMIT,
        ST_FETCH2,
        ST_DONE,
        ST_FAULT
    } state_e;

endpackage

// File: rtl/cmp_opdecode.sv
module cmp_opdecode
    import cmp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [BYTE_W-1:0] opcode,
    output op_class_e         op_class,
    output logic [CNT_W-1:0]  keep_cnt
);

    always_comb begin
        op_class = CLS_BAD;
        keep_cnt = '0;
        case (opcode)
            OP_LOAD_ADDR: begin
                op_class = CLS_LONG;
                keep_cnt = CNT_W'(2);
            end
            OP_LOOP0, OP_LOOP1, OP_SIGNAL, OP_LOOPEND0, OP_LOOPEND1: begin
                op_class = CLS_PAIR;
                keep_cnt = CNT_W'(2);
            end
            OP_LOAD, OP_STORE, OP_BARRIER: begin
                op_class = CLS_SINGLE;
                keep_cnt = CNT_W'(1);
            end
            OP_FINISH: begin
                op_class = CLS_FINISH;
                keep_cnt = CNT_W'(1);
            end
            default: begin
                op_class = CLS_BAD;
                keep_cnt = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmp_lane_pick.sv
module cmp_lane_pick #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANES-1:0]  mask,
    output logic [BYTE_W-1:0] pick_byte,
    output logic [LANES-1:0]  mask_next,
    output logic              pick_last
);

    logic [LANES-1:0]  lowest;
    logic [BYTE_W-1:0] lane_or [LANES+1];

    assign mask_next = mask & (mask - LANES'(1));
    assign lowest    = mask & ~(mask - LANES'(1));
    assign pick_last = (mask_next == '0);

    assign lane_or[0] = '0;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_or[i+1] = lane_or[i]
                            | (word[i*BYTE_W +: BYTE_W] & {BYTE_W{lowest[i]}});
    end
    assign pick_byte = lane_or[LANES];

endmodule

// File: rtl/padded_stream_compactor.sv
module padded_stream_compactor
    import cmp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              done,
    output logic              error
);

    localparam int LANES = WORD_W / BYTE_W;
    localparam int CNT_W = $clog2(LANES + 1);

    typedef struct packed {
        state_e            st;
        logic [WORD_W-1:0] word;
        logic [LANES-1:0]  mask;
        logic              more;
        logic              fin;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_FETCH, word: '0, mask: '0, more: 1'b0, fin: 1'b0};

    regs_t regs_d, regs_q;

    op_class_e         dec_class;
    logic [CNT_W-1:0]  dec_keep;
    logic [LANES-1:0]  keep_mask;
    logic [LANES-1:0]  pick_next;
    logic              pick_last;
    logic [BYTE_W-1:0] pick_byte;

    cmp_opdecode #(.BYTE_W(BYTE_W), .LANES(LANES)) i_dec (
        .opcode   (in_data[BYTE_W-1:0]),
        .op_class (dec_class),
        .keep_cnt (dec_keep)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign keep_mask[i] = (CNT_W'(i) < dec_keep);
    end

    cmp_lane_pick #(.BYTE_W(BYTE_W), .LANES(LANES)) i_pick (
        .word      (regs_q.word),
        .mask      (regs_q.mask),
        .pick_byte (pick_byte),
        .mask_next (pick_next),
        .pick_last (pick_last)
    );

    always_comb begin
        regs_d    = regs_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        case (regs_q.st)
            ST_FETCH: begin
                in_ready = !clear;
                if (in_valid) begin
                    if (dec_class == CLS_BAD) begin
                        regs_d.st = ST_FAULT;
                    end else begin
                        regs_d.word = in_data;
                        regs_d.mask = keep_mask;
                        regs_d.more = (dec_class == CLS_LONG);
                        regs_d.fin  = (dec_class == CLS_FINISH);
                        regs_d.st   = ST_EMIT;
                    end
                end
            end
            ST_FETCH2: begin
                in_ready = !clear;
                if (in_valid) begin
                    regs_d.word = in_data;
                    regs_d.mask = '1;
                    regs_d.more = 1'b0;
                    regs_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    regs_d.mask = pick_next;
                    if (pick_last) begin
                        if (regs_q.more)     regs_d.st = ST_FETCH2;
                        else if (regs_q.fin) regs_d.st = ST_DONE;
                        else                 regs_d.st = ST_FETCH;
                    end
                end
            end
            default: begin
            end
        endcase
        if (clear) regs_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign out_data = pick_byte;
    assign done     = (regs_q.st == ST_DONE);
    assign error    = (regs_q.st == ST_FAULT);

endmodule

// File: rtl/padded_stream_compactor_chk.sv
module padded_stream_compactor_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              done,
    input logic              error
);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !clear |=> out_valid && $stable(out_data));

    a_r5_done_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready && out_data == '0));

    a_r6_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> !$past(out_valid));

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clear |=> done && !in_ready && !out_valid);

    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error && !clear |=> error && !in_ready && !out_valid);

    a_r8_clear_home: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !done && !error && !out_valid);

endmodule

bind padded_stream_compactor padded_stream_compactor_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .error     (error)
);

// File: tb/test_padded_stream_compactor.sv
`timescale 1ns/1ps
module test_padded_stream_compactor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        done;
    logic        error;

    int errors = 0;
    int checks = 0;
    int bp_mode = 0;
    int bp_cnt = 0;
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    padded_stream_compactor i_padded_stream_compactor (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // back-pressure pattern on out_ready
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            bp_cnt++;
            case (bp_mode)
                0: out_ready = 1'b1;
                1: out_ready = (bp_cnt % 3) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    // collect bytes; check R9 on every offered byte
    initial begin
        logic       prev_stall = 1'b0;
        logic [7:0] prev_byte  = '0;
        forever begin
            @(negedge clk);
            if (out_valid) begin
                chk(!in_ready, "R9 ready overlap", in_ready, 0);
                if (prev_stall && !clear) chk(out_data == prev_byte, "R9 hold", out_data, prev_byte);
                if (out_ready) got.push_back(out_data);
            end
            prev_stall = out_valid && !out_ready && !clear;
            prev_byte  = out_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int keep_of(input logic [7:0] op);
        case (op)
            8'hBC: return 6;
            8'h20, 8'h22, 8'h34, 8'h38, 8'h3C: return 2;
            8'h04, 8'h08, 8'h13, 8'h00: return 1;
            default: return -1;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] op);
        int k = keep_of(op);
        if (op == 8'h00) return "R5";
        if (k == 6) return "R2";
        if (k == 2) return "R3";
        if (k == 1) return "R4";
        return "R6";
    endfunction

    task automatic send_word(input logic [31:0] w, output bit taken);
        int n = 0;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = w;
        taken    = 1'b0;
        while (!taken && n < 60) begin
            @(negedge clk);
            if (in_ready) taken = 1'b1;
            @(posedge clk); #1;
            n++;
        end
        in_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1; clear = 1'b1;
        @(posedge clk); #1; clear = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        bit tk;
        logic [7:0] exp_q[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1 && out_valid == 0, "R1 handshake", {in_ready, out_valid}, 2'b10);
        chk(done == 0 && error == 0, "R1 flags", {done, error}, 0);

        // Sweep every opcode value with distinct padding
        for (int op = 0; op < 256; op++) begin
            logic [31:0] w1, w2;
            int k;
            string rq;
            bp_mode = op % 2;
            pulse_clear();
            got.delete();
            w1 = {8'(op ^ 8'hA5), 8'(op + 8'h11), 8'(~op), 8'(op)};
            w2 = {8'(op + 8'h44), 8'(op ^ 8'h3C), 8'(op + 8'h77), 8'(op ^ 8'hC3)};
            k  = keep_of(8'(op));
            rq = req_of(8'(op));
            send_word(w1, tk);
            if (k == 6) send_word(w2, tk);
            settle(20);
            exp_q.delete();
            if (k >= 1) exp_q.push_back(w1[7:0]);
            if (k >= 2) exp_q.push_back(w1[15:8]);
            if (k == 6) for (int b = 0; b < 4; b++) exp_q.push_back(w2[b*8 +: 8]);
            chk(got.size() == exp_q.size(), {rq, " byte count"}, got.size(), exp_q.size());
            if (got.size() == exp_q.size())
                for (int b = 0; b < got.size(); b++)
                    chk(got[b] == exp_q[b], {rq, " byte value"}, got[b], exp_q[b]);
            if (k < 0)
                chk(error && !done && !in_ready, "R6 fault flag", {error, done, in_ready}, 3'b100);
            else if (op == 0)
                chk(done && !error && !in_ready, "R5 done flag", {done, error, in_ready}, 3'b100);
            else
                chk(!done && !error && in_ready, {rq, " back to fetch"}, {done, error, in_ready}, 3'b001);
        end

        // Mixed program under stall, then input after done is ignored
        bp_mode = 1;
        pulse_clear();
        got.delete();
        send_word(32'h0000_11BC, tk);
        send_word(32'hD4C3_B2A1, tk);
        send_word(32'h9988_0F20, tk);
        send_word(32'h7766_5508, tk);
        send_word(32'h4433_2213, tk);
        send_word(32'hEEDD_0338, tk);
        send_word(32'h0000_0000, tk);
        settle(20);
        exp_q = '{8'hBC, 8'h11, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h20, 8'h0F,
                  8'h08, 8'h13, 8'h38, 8'h03, 8'h00};
        chk(got.size() == exp_q.size(), "R2 program length", got.size(), exp_q.size());
        if (got.size() == exp_q.size())
            for (int b = 0; b < got.size(); b++)
                chk(got[b] == exp_q[b], "R3 program byte", got[b], exp_q[b]);
        chk(done == 1, "R5 program done", done, 1);
        got.delete();
        send_word(32'h0000_0004, tk);
        chk(tk == 0, "R7 word after done", tk, 0);
        settle(5);
        chk(got.size() == 0 && !out_valid && done, "R7 no output after done", got.size(), 0);

        // Input after error is ignored
        pulse_clear();
        send_word(32'h0000_0021, tk);
        settle(3);
        got.delete();
        send_word(32'h0000_0004, tk);
        chk(tk == 0, "R7 word after error", tk, 0);
        chk(got.size() == 0 && error, "R7 no output after error", got.size(), 0);

        // Clear partway through a two-slot instruction
        bp_mode = 2;
        pulse_clear();
        got.delete();
        send_word(32'h0000_55BC, tk);
        settle(2);
        chk(out_valid == 1, "R9 stalled byte offered", out_valid, 1);
        chk(out_data == 8'hBC, "R9 stalled byte value", out_data, 8'hBC);
        pulse_clear();
        @(negedge clk);
        chk(in_ready && !out_valid && !done && !error, "R8 clear mid-instruction",
            {in_ready, out_valid, done, error}, 4'b1000);
        bp_mode = 0;
        got.delete();
        send_word(32'h0000_0008, tk);
        settle(4);
        chk(got.size() == 1 && got[0] == 8'h08, "R8 fresh decode after clear", got.size(), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule